// File: doc/BRIEF.md
# Write-Start Qualifier with Supply Lockout and Strobe Glitch Filter

This block stands in front of the write engine of a byte-wide non-volatile memory. It takes the raw active-low chip-select, write-enable and output-enable strobes and turns them into a single-clock write-start pulse. The pulse is issued only when a write has really been requested: the select and write strobes are both low, the output enable is high, and this combination has been held for a minimum number of clocks. Shorter pulses are treated as noise and are dropped.

A supply-good flag from an external comparator gates everything. While the flag is low no write can begin. After it rises, a lockout counter must run a full power-on delay before writes are accepted. A drop of the flag at any moment restarts that delay and cancels any qualification in progress. All four inputs pass through a synchronizer first. Each held strobe assertion yields at most one write-start, and the strobes must be released before a further one is possible.

Top module: `wr_inhibit_guard`

## Requirements
- R1: While `rst` is high, `wr_start` is 0. Reset clears the power-on lockout, so after reset a full `PWR_DELAY` wait is needed again even if `pwr_ok` stayed high.
- R2: No `wr_start` is issued while the synchronized `pwr_ok` is low, whatever the strobes do.
- R3: After synchronized `pwr_ok` becomes high, writes stay locked out until it has been high on `PWR_DELAY` consecutive clocks. Only after that does the qualifying hold count begin.
- R4: With `oe_n` low (0), no `wr_start` is issued even if `cs_n` and `we_n` are both low.
- R5: With `cs_n` high (1) or `we_n` high (1), no `wr_start` is issued.
- R6: A write condition (`cs_n`=0, `we_n`=0, `oe_n`=1) that holds on fewer than `FILT_LEN` consecutive synchronized clocks never produces `wr_start`. This applies whether `we_n` or `cs_n` ends the glitch.
- R7: `wr_start` is high for exactly one clock. It rises at the clock edge on which the qualified condition completes its `FILT_LEN`-th consecutive cycle.
- R8: Each continuous qualified assertion produces exactly one `wr_start`. The condition must drop before another can be issued.
- R9: A low on synchronized `pwr_ok` restarts the lockout count from zero and cancels a qualification that is in progress.
- R10: Each input passes through `SYNC_STAGES` flip-flops. With the lockout already satisfied, a write condition first applied before edge t gives `wr_start` high after edge t + `SYNC_STAGES` + `FILT_LEN` - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Raw chip select, active low |
| we_n | input | 1 | Raw write enable, active low |
| oe_n | input | 1 | Raw output enable, active low |
| pwr_ok | input | 1 | Supply-good flag from the comparator, high when the supply is good |
| wr_start | output | 1 | Registered one-clock write-start pulse |

## Verification
An input applied before edge t reaches the qualifier logic at edge t + `SYNC_STAGES`. The lockout counter advances one step per clock after that, and the hold counter raises `wr_start` on the `FILT_LEN`-th qualified edge, so a fresh write in an unlocked state shows up `SYNC_STAGES` + `FILT_LEN` edges after it was applied. The bench feeds the raw inputs into a delay queue of `SYNC_STAGES` entries and keeps run-length integers for supply-good and for the qualified condition. From these it predicts `wr_start` for every edge and compares 1 ns after the edge. Scenario checks also count pulses over windows that cover glitches, inhibit combinations, supply drops and reset. The wait from a strobe assertion to its pulse is measured directly.

// File: rtl/wig_pkg.sv
package wig_pkg;

  // Synchronized view of the raw pins, all active low except pwr_ok.
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic pwr_ok;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  // Safe value: no strobe asserted, supply reported bad.
  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, pwr_ok: 1'b0};

endpackage

// File: rtl/wig_sync.sv
module wig_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wig_lockout.sv
module wig_lockout #(
  parameter int DELAY = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic ready
);

  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  // Counts consecutive good-supply cycles, saturating at LIMIT.
  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == LIMIT);

endmodule

// File: rtl/wig_filter.sv
module wig_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic start
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] hold_q;
  logic          fired_q;
  logic          start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      fired_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!qual) begin
        hold_q  <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q) begin
        if (hold_q == LAST) begin
          start_q <= 1'b1;
          fired_q <= 1'b1;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end
    end
  end

  assign start = start_q;

endmodule

// File: rtl/wr_inhibit_guard.sv
module wr_inhibit_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int PWR_DELAY   = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic pwr_ok,
  output logic wr_start
);

  import wig_pkg::*;

  strobe_t raw_pins;
  strobe_t sync_pins;

  logic s_cs_n;
  logic s_we_n;
  logic s_oe_n;
  logic s_pwr_ok;
  logic pwr_ready;
  logic write_qual;

  always_comb begin
    raw_pins.cs_n   = cs_n;
    raw_pins.we_n   = we_n;
    raw_pins.oe_n   = oe_n;
    raw_pins.pwr_ok = pwr_ok;
  end

  wig_sync #(
    .W       (STROBE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STROBE_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_pins),
    .q   (sync_pins)
  );

  assign s_cs_n   = sync_pins.cs_n;
  assign s_we_n   = sync_pins.we_n;
  assign s_oe_n   = sync_pins.oe_n;
  assign s_pwr_ok = sync_pins.pwr_ok;

  wig_lockout #(
    .DELAY (PWR_DELAY)
  ) u_lockout (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (s_pwr_ok),
    .ready     (pwr_ready)
  );

  // Write is requested only with select and write low, output enable high,
  // and supply both present and past its power-on delay.
  assign write_qual = pwr_ready & s_pwr_ok & ~s_cs_n & ~s_we_n & s_oe_n;

  wig_filter #(
    .LEN (FILT_LEN)
  ) u_filter (
    .clk   (clk),
    .rst   (rst),
    .qual  (write_qual),
    .start (wr_start)
  );

endmodule

// File: rtl/wr_inhibit_guard_chk.sv
module wr_inhibit_guard_chk (
  input logic clk,
  input logic rst,
  input logic s_cs_n,
  input logic s_we_n,
  input logic s_oe_n,
  input logic s_pwr_ok,
  input logic pwr_ready,
  input logic wr_start
);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !wr_start);

  // R9
  lockout_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !s_pwr_ok |=> !pwr_ready);

  // R3
  ready_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_ready) |-> $past(s_pwr_ok));

  // R2
  supply_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(pwr_ready && s_pwr_ok));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(s_oe_n));

  // R5
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(!s_cs_n && !s_we_n));

endmodule

bind wr_inhibit_guard wr_inhibit_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_cs_n    (s_cs_n),
  .s_we_n    (s_we_n),
  .s_oe_n    (s_oe_n),
  .s_pwr_ok  (s_pwr_ok),
  .pwr_ready (pwr_ready),
  .wr_start  (wr_start)
);

// File: tb/wr_inhibit_guard_bench.sv
`timescale 1ns/100ps
module wr_inhibit_guard_bench;

  localparam int SS  = 2;
  localparam int FL  = 4;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_ok = 1'b0;
  logic wr_start;

  always #2.5 clk = ~clk;

  wr_inhibit_guard #(
    .SYNC_STAGES (SS),
    .FILT_LEN    (FL),
    .PWR_DELAY   (DLY)
  ) u_wr_inhibit_guard (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .pwr_ok   (pwr_ok),
    .wr_start (wr_start)
  );

  int    checks = 0;
  int    fails  = 0;
  int    pulses = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Behavioural reference: delay queue plus run lengths.
  logic [3:0] hist [$];
  int okrun;
  int qrun;
  bit exp_start;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i < SS; i++) hist.push_back(4'b1110);
      okrun = 0;
      qrun = 0;
      exp_start = 0;
    end else begin
      logic [3:0] d;
      bit rdy;
      bit q;
      d = hist.pop_front();
      hist.push_back({cs_n, we_n, oe_n, pwr_ok});
      rdy = (okrun >= DLY);
      q = rdy && d[0] && !d[3] && !d[2] && d[1];
      okrun = d[0] ? okrun + 1 : 0;
      qrun = q ? qrun + 1 : 0;
      exp_start = (qrun == FL);
    end
    #1;
    checks++;
    if (wr_start !== exp_start) begin
      fails++;
      $display("FAIL %s: wr_start=%0b expected %0b at %0t", cur_req, wr_start, exp_start, $time);
    end
    if (wr_start === 1'b1) pulses++;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic c, input logic w, input logic o, input logic p, input int n);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; pwr_ok = p;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    int p0;
    int n;
    repeat (4) @(negedge clk);
    check_eq("R1", int'(wr_start), 0);
    rst = 1'b0;

    // R2: strobes asserted, supply low
    cur_req = "R2"; p0 = pulses;
    apply(0, 0, 1, 0, 30);
    check_eq("R2", pulses - p0, 0);

    // R3: supply rises with strobes held; single pulse after lockout
    cur_req = "R3"; p0 = pulses;
    apply(0, 0, 1, 1, DLY - 2);
    check_eq("R3", pulses - p0, 0);
    apply(0, 0, 1, 1, FL + 12);
    check_eq("R3", pulses - p0, 1);
    apply(1, 1, 1, 1, 5);

    // R4: output enable low
    cur_req = "R4"; p0 = pulses;
    apply(0, 0, 0, 1, 20);
    check_eq("R4", pulses - p0, 0);
    apply(1, 1, 1, 1, 3);

    // R5: one of select/write high
    cur_req = "R5"; p0 = pulses;
    apply(1, 0, 1, 1, 20);
    apply(0, 1, 1, 1, 20);
    check_eq("R5", pulses - p0, 0);
    apply(1, 1, 1, 1, 3);

    // R6: short pulses on write then on select
    cur_req = "R6"; p0 = pulses;
    for (int k = 0; k < 4; k++) begin
      apply(0, 0, 1, 1, FL - 1);
      apply(0, 1, 1, 1, 3);
    end
    for (int k = 0; k < 4; k++) begin
      apply(0, 0, 1, 1, FL - 1);
      apply(1, 0, 1, 1, 3);
    end
    check_eq("R6", pulses - p0, 0);
    apply(1, 1, 1, 1, 4);

    // R10 / R7: latency of a fresh assertion
    cur_req = "R10"; p0 = pulses;
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; pwr_ok = 1;
    n = 0;
    do begin
      @(posedge clk);
      #1.5;
      n++;
    end while (wr_start !== 1'b1 && n < 50);
    check_eq("R10", n, SS + FL);
    @(posedge clk);
    #1.5;
    check_eq("R7", int'(wr_start), 0);
    cur_req = "R8";
    apply(0, 0, 1, 1, 12);
    check_eq("R8", pulses - p0, 1);
    apply(1, 1, 1, 1, 3);

    // R8: repeated separate assertions
    p0 = pulses;
    for (int k = 0; k < 3; k++) begin
      apply(0, 0, 1, 1, FL + 4);
      apply(1, 1, 1, 1, 3);
    end
    check_eq("R8", pulses - p0, 3);

    // R9: supply drop mid-qualification
    cur_req = "R9"; p0 = pulses;
    apply(0, 0, 1, 1, 2);
    apply(0, 0, 1, 0, 1);
    apply(0, 0, 1, 1, DLY - 5);
    check_eq("R9", pulses - p0, 0);
    apply(0, 0, 1, 1, FL + 20);
    check_eq("R9", pulses - p0, 1);
    apply(1, 1, 1, 1, 3);

    // R1: reset clears the lockout while supply stays good
    cur_req = "R1"; p0 = pulses;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1", int'(wr_start), 0);
    rst = 1'b0;
    apply(0, 0, 1, 1, DLY - 2);
    check_eq("R1", pulses - p0, 0);
    apply(0, 0, 1, 1, FL + 12);
    check_eq("R1", pulses - p0, 1);
    apply(1, 1, 1, 1, 4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule